// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a small controller into and out of three power-reduction modes. Software writes a two-bit mode code into a control register. While the processor runs, a write moves the sequencer into the requested mode on the next clock edge. From then on the sequencer drives one enable line for each of these functions: the processor clock, the main oscillator, the internal RC oscillator, the brownout detector, the comparators, the watchdog and the real-time clock. The oscillators and the peripherals themselves sit outside the block. They see only these enable lines and report back through interrupt request lines.

Light sleep (idle) stops only the processor clock. Any interrupt that is both requested and enabled brings the processor back on the next cycle. The two deep modes also stop the main oscillator. The deepest mode additionally turns off brownout detection and the comparators. A deep mode ends only on an interrupt that is requested, enabled and also selected in a per-source wake mask register. After such a wake the oscillator restarts at once, but the processor clock stays off for a fixed settling window. A synchronous reset ends every mode.

Top module: `lpm_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) returns the block to the running state from any mode: mode_q = 00, wake mask = 0, cpu_clk_en = 1 and osc_en = 1.
- R2: In the running state, mode_wr loads mode_wdata into mode_q at the next edge. The encoding is 00 run, 01 idle, 10 power-down, 11 total power-down. A nonzero code takes effect at that same edge, and a written 00 leaves the block running.
- R3: In idle, cpu_clk_en = 0 and osc_en = 1, while bod_en, cmp_en, wdt_en and rtc_en follow cfg_bod_en, cfg_cmp_en, cfg_wdt_en and cfg_rtc_en.
- R4: In idle, an edge at which any bit of irq_req & irq_en is set returns the block to running at that edge, with mode_q = 00. Requested but disabled interrupts leave idle unchanged.
- R5: In power-down (10), cpu_clk_en = 0 and osc_en = 0, while bod_en, cmp_en, wdt_en and rtc_en follow their configuration inputs.
- R6: In total power-down (11), the enables are the same as in power-down, except that bod_en = 0 and cmp_en = 0 whatever the configuration.
- R7: rc_osc_en equals cfg_rc_sysclk outside the two deep modes. Inside them it equals cfg_rc_sysclk & cfg_rtc_en.
- R8: A deep mode ends only at an edge where any bit of irq_req & irq_en & mask is set. Enabled interrupts whose mask bit is 0 leave the mode unchanged.
- R9: At a deep wake, mode_q becomes 00 and osc_en becomes 1 at that edge. cpu_clk_en then stays 0 for exactly STAB_CYCLES cycles (default 256) and becomes 1 after that.
- R10: Writes to mode_q are ignored in every state other than running.
- R11: The wake mask register loads mask_wdata on mask_wr at the next edge in any state, and the new value governs deep wakes from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode code to write |
| mask_wr | input | 1 | Wake mask write strobe |
| mask_wdata | input | N_IRQ | Wake mask value, one bit per interrupt source |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Interrupt enables |
| cfg_bod_en | input | 1 | Brownout detection enabled by software |
| cfg_cmp_en | input | 1 | Comparators powered by their own control |
| cfg_wdt_en | input | 1 | Watchdog enabled |
| cfg_rtc_en | input | 1 | Real-time clock enabled |
| cfg_rc_sysclk | input | 1 | Internal RC oscillator is the system clock |
| mode_q | output | 2 | Current mode register value |
| cpu_clk_en | output | 1 | Processor clock enable |
| osc_en | output | 1 | Main oscillator enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| bod_en | output | 1 | Brownout detector enable |
| cmp_en | output | 1 | Comparator enable |
| wdt_en | output | 1 | Watchdog enable |
| rtc_en | output | 1 | Real-time clock enable |

## Verification
Directed sequences enter each mode with all configuration inputs set. In idle they offer requested but disabled interrupts, which must not wake, and then an enabled one, which separates the two idle wake rules. In power-down they offer enabled but unmasked sources, which must be ignored, and then a masked one, which separates the deep wake qualifier from the idle one. The settling window is counted cycle by cycle to tell an early or a late processor clock apart. A long random run mixes mode writes, mask writes, sparse interrupt bursts, configuration flips and occasional resets. Each cycle it compares every output against a requirement-level model, so wrong gating in one mode or a wrong RC oscillator rule shows up under many configurations.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_PD   = 2'b10,
        MODE_TPD  = 2'b11
    } lpm_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_PD,
        ST_TPD,
        ST_WARM
    } lpm_state_e;

    typedef struct packed {
        logic bod;
        logic cmp;
        logic wdt;
        logic rtc;
        logic rc_sysclk;
    } lpm_cfg_t;

    typedef struct packed {
        logic cpu_clk;
        logic osc;
        logic rc_osc;
        logic bod;
        logic cmp;
        logic wdt;
        logic rtc;
    } lpm_en_t;

    function automatic lpm_state_e mode_to_state(lpm_mode_e m);
        case (m)
            MODE_IDLE: return ST_IDLE;
            MODE_PD:   return ST_PD;
            MODE_TPD:  return ST_TPD;
            default:   return ST_RUN;
        endcase
    endfunction

    function automatic logic is_deep(lpm_state_e s);
        return (s == ST_PD) || (s == ST_TPD);
    endfunction

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mask_wr,
    input  logic [N_IRQ-1:0] mask_wdata,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             any_wake,
    output logic             deep_wake
);

    logic [N_IRQ-1:0] mask_q;
    logic [N_IRQ-1:0] live;
    logic [N_IRQ-1:0] deep_live;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= mask_wdata;
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        assign live[i]      = irq_req[i] & irq_en[i];
        assign deep_live[i] = live[i] & mask_q[i];
    end

    assign any_wake  = |live;
    assign deep_wake = |deep_live;

    // R1
    mask_clear_after_reset_chk: assert property (@(posedge clk)
        rst |=> (mask_q == '0));

endmodule

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
    parameter int STAB_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    output logic done
);

    localparam int CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || start)
            cnt <= '0;
        else if (active && !done)
            cnt <= cnt + 1'b1;
    end

    assign done = active && (cnt == LAST);

    // R9
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= LAST));

endmodule

// File: rtl/lpm_enable_decode.sv
module lpm_enable_decode
    import lpm_pkg::*;
(
    input  lpm_state_e st,
    input  lpm_cfg_t   cfg,
    output lpm_en_t    en
);

    logic deep;
    logic total;

    always_comb begin
        deep       = is_deep(st);
        total      = (st == ST_TPD);
        en.cpu_clk = (st == ST_RUN);
        en.osc     = !deep;
        en.rc_osc  = cfg.rc_sysclk && (!deep || cfg.rtc);
        en.bod     = cfg.bod && !total;
        en.cmp     = cfg.cmp && !total;
        en.wdt     = cfg.wdt;
        en.rtc     = cfg.rtc;
    end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int N_IRQ       = 4,
    parameter int STAB_CYCLES = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic             mask_wr,
    input  logic [N_IRQ-1:0] mask_wdata,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             cfg_bod_en,
    input  logic             cfg_cmp_en,
    input  logic             cfg_wdt_en,
    input  logic             cfg_rtc_en,
    input  logic             cfg_rc_sysclk,
    output logic [1:0]       mode_q,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             rc_osc_en,
    output logic             bod_en,
    output logic             cmp_en,
    output logic             wdt_en,
    output logic             rtc_en
);

    lpm_state_e st;
    lpm_mode_e  mode_r;
    logic       any_wake;
    logic       deep_wake;
    logic       tmr_start;
    logic       tmr_done;
    lpm_cfg_t   cfg;
    lpm_en_t    en;

    lpm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .any_wake   (any_wake),
        .deep_wake  (deep_wake)
    );

    assign tmr_start = is_deep(st) && deep_wake;

    lpm_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (tmr_start),
        .active (st == ST_WARM),
        .done   (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_RUN;
            mode_r <= MODE_RUN;
        end else begin
            case (st)
                ST_RUN: begin
                    if (mode_wr) begin
                        mode_r <= lpm_mode_e'(mode_wdata);
                        st     <= mode_to_state(lpm_mode_e'(mode_wdata));
                    end
                end
                ST_IDLE: begin
                    if (any_wake) begin
                        mode_r <= MODE_RUN;
                        st     <= ST_RUN;
                    end
                end
                ST_PD, ST_TPD: begin
                    if (deep_wake) begin
                        mode_r <= MODE_RUN;
                        st     <= ST_WARM;
                    end
                end
                ST_WARM: begin
                    if (tmr_done)
                        st <= ST_RUN;
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    assign cfg = '{bod: cfg_bod_en, cmp: cfg_cmp_en, wdt: cfg_wdt_en,
                   rtc: cfg_rtc_en, rc_sysclk: cfg_rc_sysclk};

    lpm_enable_decode u_dec (
        .st  (st),
        .cfg (cfg),
        .en  (en)
    );

    assign mode_q     = mode_r;
    assign cpu_clk_en = en.cpu_clk;
    assign osc_en     = en.osc;
    assign rc_osc_en  = en.rc_osc;
    assign bod_en     = en.bod;
    assign cmp_en     = en.cmp;
    assign wdt_en     = en.wdt;
    assign rtc_en     = en.rtc;

    // R3
    idle_cpu_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (!cpu_clk_en && osc_en));

    // R4
    idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && any_wake) |=> (st == ST_RUN && mode_q == 2'b00));

    // R6
    tpd_analog_off_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TPD) |-> (!bod_en && !cmp_en && !osc_en));

    // R8
    deep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_deep(st) && !deep_wake) |=> (st == $past(st)));

    // R9
    warm_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WARM && !tmr_done) |=> (!cpu_clk_en && osc_en));

    // R10
    no_write_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && mode_wr && !any_wake) |=> (st == ST_IDLE && $stable(mode_q)));

endmodule

// File: tb/test_lpm_sequencer.sv
module test_lpm_sequencer;
    import lpm_pkg::*;

    localparam int N    = 4;
    localparam int STAB = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_wr = 1'b0;
    logic [1:0]   mode_wdata = 2'b00;
    logic         mask_wr = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_en = '0;
    logic         cfg_bod = 1'b1, cfg_cmp = 1'b1, cfg_wdt = 1'b1, cfg_rtc = 1'b1, cfg_rc = 1'b0;
    logic [1:0]   mode_q;
    logic         cpu_clk_en, osc_en, rc_osc_en, bod_en, cmp_en, wdt_en, rtc_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int           m_st = 0;
    logic [1:0]   m_mode = 2'b00;
    logic [N-1:0] m_mask = '0;
    int           m_cnt = 0;

    always #5 clk = ~clk;

    lpm_sequencer #(.N_IRQ(N), .STAB_CYCLES(STAB)) i_lpm_sequencer (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .irq_req(irq_req), .irq_en(irq_en),
        .cfg_bod_en(cfg_bod), .cfg_cmp_en(cfg_cmp), .cfg_wdt_en(cfg_wdt),
        .cfg_rtc_en(cfg_rtc), .cfg_rc_sysclk(cfg_rc),
        .mode_q(mode_q), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .rc_osc_en(rc_osc_en),
        .bod_en(bod_en), .cmp_en(cmp_en), .wdt_en(wdt_en), .rtc_en(rtc_en)
    );

    function automatic logic [8:0] expected();
        bit deep = (m_st == 2) || (m_st == 3);
        bit tot  = (m_st == 3);
        return {m_mode, (m_st == 0), !deep, cfg_rc && (!deep || cfg_rtc),
                cfg_bod && !tot, cfg_cmp && !tot, cfg_wdt, cfg_rtc};
    endfunction

    function automatic string auto_tag();
        case (m_st)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic model_step();
        if (rst) begin
            m_st = 0; m_mode = 2'b00; m_mask = '0; m_cnt = 0;
        end else begin
            logic [N-1:0] old_mask = m_mask;
            if (mask_wr) m_mask = mask_wdata;
            case (m_st)
                0: if (mode_wr) begin m_mode = mode_wdata; m_st = int'(mode_wdata); end
                1: if (|(irq_req & irq_en)) begin m_st = 0; m_mode = 2'b00; end
                2, 3: if (|(irq_req & irq_en & old_mask)) begin
                    m_st = 4; m_cnt = 0; m_mode = 2'b00;
                end
                default: if (m_cnt == STAB - 1) m_st = 0; else m_cnt++;
            endcase
        end
    endtask

    task automatic check(string tag);
        logic [8:0] act = {mode_q, cpu_clk_en, osc_en, rc_osc_en, bod_en, cmp_en, wdt_en, rtc_en};
        logic [8:0] exp = expected();
        string t = (tag == "") ? auto_tag() : tag;
        if (tag == "" && act != exp && (act ^ exp) == 9'b000010000) t = "R7";
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b (state %0d)", t, act, exp, m_st);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5a));
        @(negedge clk);
        tick("R1");
        rst = 1'b0;
        tick("R1");

        // R2 / R3 / R4 / R10: idle entry, disabled irq, ignored write, enabled irq
        mode_wr = 1'b1; mode_wdata = 2'b01; tick("R2");
        mode_wr = 1'b0; irq_req = 4'b0101; irq_en = 4'b0000; tick("R4");
        tick("R3");
        mode_wr = 1'b1; mode_wdata = 2'b10; tick("R10");
        mode_wr = 1'b0; irq_en = 4'b0001; tick("R4");
        irq_req = '0;

        // R11 / R5 / R8 / R9: masked deep wake and settling window
        mask_wr = 1'b1; mask_wdata = 4'b0010; tick("R11");
        mask_wr = 1'b0; mode_wr = 1'b1; mode_wdata = 2'b10; tick("R5");
        mode_wr = 1'b0; irq_en = 4'b1111; irq_req = 4'b1101; tick("R8");
        tick("R8");
        irq_req = 4'b0010; tick("R9");
        irq_req = '0;
        for (int k = 0; k < STAB; k++) tick("R9");
        tick("R9");

        // R6 / R7: total power-down with RC clock and real-time clock
        cfg_rc = 1'b1; cfg_rtc = 1'b1;
        mode_wr = 1'b1; mode_wdata = 2'b11; tick("R6");
        mode_wr = 1'b0; tick("R7");
        cfg_rtc = 1'b0; tick("R7");
        irq_req = 4'b0010; tick("R9");
        irq_req = '0;
        for (int k = 0; k < STAB + 1; k++) tick("R9");

        // R1: reset out of power-down
        mode_wr = 1'b1; mode_wdata = 2'b10; tick("R5");
        mode_wr = 1'b0; rst = 1'b1; tick("R1");
        rst = 1'b0; tick("R1");

        for (int i = 0; i < 6000; i++) begin
            mode_wr    = ($urandom % 6 == 0);
            mode_wdata = 2'($urandom);
            mask_wr    = ($urandom % 20 == 0);
            mask_wdata = N'($urandom);
            irq_req    = ($urandom % 10 == 0) ? N'($urandom) : '0;
            irq_en     = N'($urandom);
            if ($urandom % 50 == 0) begin
                cfg_bod = 1'($urandom); cfg_cmp = 1'($urandom); cfg_wdt = 1'($urandom);
                cfg_rtc = 1'($urandom); cfg_rc  = 1'($urandom);
            end
            rst = ($urandom % 900 == 0);
            tick("");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule